// File: doc/BRIEF.md
# Framebuffer Descriptor and Buffer-Swap Controller

This block keeps the descriptor that an external scaler reads to scan a framebuffer out of memory. The descriptor holds the image width, image height, pixel format, base address, padded line stride and an enable flag. Software fills a shadow copy of the descriptor through a simple register write port. The shadow copy moves into the active descriptor only on the rising edge of the display's vertical-blank input. Software can therefore queue the next buffer address at any time, and the picture never changes partway through a frame.

The line stride is the line's byte count rounded up to a multiple of either 256 or 16 bytes. The granularity is chosen per descriptor. A combinational lookup returns the start address of any row of the active image, clamped to the last row. A one-cycle pulse marks each commit so software can pace its own frame cadence. The enable flag takes effect as soon as it is written: while it is low, the scaler shows the core's normal video instead of the framebuffer.

Top module: `fb_desc_ctrl`

## Requirements
- R1: After reset, every active descriptor output is zero and `swap_pend_o`, `vbl_pulse_o` and `fb_enable_o` are low.
- R2: Register writes use word offsets. Offset 0x0 is control: bit 0 enable, bits 2:1 format, bit 3 fine granularity. Offset 0x4 holds width in bits 11:0 and height in bits 27:16. Offset 0x8 holds the base address. Writes to width, height, format, granularity or base do not change the active outputs before the next commit.
- R3: The active stride equals width × bytes per pixel, rounded up to a multiple of 256, or of 16 when the granularity bit is 1. Format codes 0, 1, 2 and 3 give 1, 2, 3 and 4 bytes per pixel. For example, 800 pixels in format 2 gives 2560, or 2400 with fine granularity.
- R4: A base-address write sets `swap_pend_o` on the next cycle. A commit clears it, unless a base write arrives in the same cycle as the commit.
- R5: A commit happens only on a low-to-high transition of `vblank_i`. Holding `vblank_i` high does not commit values written meanwhile.
- R6: `vbl_pulse_o` is high for exactly one cycle. That cycle is the first cycle in which the newly committed values appear on the active outputs.
- R7: `row_addr_o` equals active base + row × active stride, with the row clamped to height−1 when `row_i` ≥ height. A height of zero returns the base.
- R8: The enable bit reaches `fb_enable_o` one cycle after it is written, without waiting for a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_off | input | 4 | Byte offset of the written register |
| wr_data | input | 32 | Write data |
| vblank_i | input | 1 | Vertical blank of the output display |
| row_i | input | 12 | Row index for the address lookup |
| fb_enable_o | output | 1 | Framebuffer shown instead of core video |
| fb_format_o | output | 2 | Active pixel format code |
| fb_width_o | output | 12 | Active width in pixels |
| fb_height_o | output | 12 | Active height in lines |
| fb_base_o | output | 32 | Active base address |
| fb_stride_o | output | 15 | Active padded line stride in bytes |
| row_addr_o | output | 32 | Start address of the requested row |
| swap_pend_o | output | 1 | A base write is waiting for commit |
| vbl_pulse_o | output | 1 | One-cycle commit marker |

## Verification
The assertions check every cycle that the active base moves only in a commit cycle, that the commit pulse never lasts two cycles, and that the stride stays aligned to the committed granularity. They also check that the pending flag clears after a commit without a colliding write, and that the clamped row never reaches the height. Only the bench scenarios can show the actual stride values across every format, granularity and edge width. The same holds for the exact row addresses and clamping, for the behaviour of writes made while vertical blank is held high, and for the immediate effect of the enable bit.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  typedef enum logic [1:0] {
    FMT_IDX8   = 2'd0,
    FMT_RGB16  = 2'd1,
    FMT_RGB24  = 2'd2,
    FMT_RGBX32 = 2'd3
  } fb_fmt_e;

  localparam logic [3:0] OFF_CTRL = 4'h0;
  localparam logic [3:0] OFF_DIM  = 4'h4;
  localparam logic [3:0] OFF_BASE = 4'h8;

  function automatic logic [2:0] bytes_per_px(input logic [1:0] f);
    return {1'b0, f} + 3'd1;
  endfunction
endpackage

// File: rtl/fbd_regfile.sv
module fbd_regfile
  import fbd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12,
  parameter int HGT_LSB = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              commit,
  output logic              sh_en,
  output logic [1:0]        sh_fmt,
  output logic              sh_fine,
  output logic [DIM_W-1:0]  sh_width,
  output logic [DIM_W-1:0]  sh_height,
  output logic [ADDR_W-1:0] sh_base,
  output logic              pend
);
  logic wr_ctrl, wr_dim, wr_base;
  assign wr_ctrl = wr_en && (wr_off == OFF_CTRL);
  assign wr_dim  = wr_en && (wr_off == OFF_DIM);
  assign wr_base = wr_en && (wr_off == OFF_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_en     <= 1'b0;
      sh_fmt    <= 2'd0;
      sh_fine   <= 1'b0;
      sh_width  <= '0;
      sh_height <= '0;
      sh_base   <= '0;
    end else begin
      if (wr_ctrl) begin
        sh_en   <= wr_data[0];
        sh_fmt  <= wr_data[2:1];
        sh_fine <= wr_data[3];
      end
      if (wr_dim) begin
        sh_width  <= wr_data[DIM_W-1:0];
        sh_height <= wr_data[HGT_LSB +: DIM_W];
      end
      if (wr_base) sh_base <= wr_data[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          pend <= 1'b0;
    else if (wr_base) pend <= 1'b1;
    else if (commit)  pend <= 1'b0;
  end

  // R4
  pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (commit && !wr_base) |=> !pend);
  // R4
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_base |=> pend);
endmodule

// File: rtl/fbd_stride.sv
module fbd_stride
  import fbd_pkg::*;
#(
  parameter int DIM_W     = 12,
  parameter int FINE_SH   = 4,
  parameter int COARSE_SH = 8,
  localparam int STR_W    = DIM_W + 3
) (
  input  logic [DIM_W-1:0] width,
  input  logic [1:0]       fmt,
  input  logic             fine,
  output logic [STR_W-1:0] stride
);
  localparam logic [STR_W-1:0] FINE_MASK   = STR_W'((1 << FINE_SH) - 1);
  localparam logic [STR_W-1:0] COARSE_MASK = STR_W'((1 << COARSE_SH) - 1);

  logic [STR_W-1:0] line_bytes, mask;

  always_comb begin
    line_bytes = {3'b000, width} * {{(STR_W-3){1'b0}}, bytes_per_px(fmt)};
    mask       = fine ? FINE_MASK : COARSE_MASK;
    stride     = (line_bytes + mask) & ~mask;
  end
endmodule

// File: rtl/fbd_rowaddr.sv
module fbd_rowaddr #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12,
  parameter int STR_W  = 15,
  localparam int PROD_W = DIM_W + STR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base,
  input  logic [STR_W-1:0]  stride,
  input  logic [DIM_W-1:0]  height,
  input  logic [DIM_W-1:0]  row,
  output logic [ADDR_W-1:0] addr
);
  logic [DIM_W-1:0]  eff_row;
  logic [PROD_W-1:0] offset;

  always_comb begin
    if (height == '0)        eff_row = '0;
    else if (row >= height)  eff_row = height - 1'b1;
    else                     eff_row = row;
    offset = {{STR_W{1'b0}}, eff_row} * {{DIM_W{1'b0}}, stride};
    addr   = base + ADDR_W'(offset);
  end

  // R7
  row_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    (height != '0) |-> (eff_row < height));
endmodule

// File: rtl/fb_desc_ctrl.sv
module fb_desc_ctrl
  import fbd_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int DIM_W     = 12,
  parameter int FINE_SH   = 4,
  parameter int COARSE_SH = 8,
  localparam int STR_W    = DIM_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [3:0]        wr_off,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              vblank_i,
  input  logic [DIM_W-1:0]  row_i,
  output logic              fb_enable_o,
  output logic [1:0]        fb_format_o,
  output logic [DIM_W-1:0]  fb_width_o,
  output logic [DIM_W-1:0]  fb_height_o,
  output logic [ADDR_W-1:0] fb_base_o,
  output logic [STR_W-1:0]  fb_stride_o,
  output logic [ADDR_W-1:0] row_addr_o,
  output logic              swap_pend_o,
  output logic              vbl_pulse_o
);
  logic              vbl_q, commit;
  logic              sh_fine, act_fine;
  logic [1:0]        sh_fmt;
  logic [DIM_W-1:0]  sh_width, sh_height;
  logic [ADDR_W-1:0] sh_base;
  logic [STR_W-1:0]  sh_stride;

  always_ff @(posedge clk) begin
    if (rst) vbl_q <= 1'b0;
    else     vbl_q <= vblank_i;
  end
  assign commit = vblank_i && !vbl_q;

  fbd_regfile #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .DIM_W(DIM_W), .HGT_LSB(16)
  ) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .commit(commit), .sh_en(fb_enable_o), .sh_fmt(sh_fmt), .sh_fine(sh_fine),
    .sh_width(sh_width), .sh_height(sh_height), .sh_base(sh_base),
    .pend(swap_pend_o)
  );

  fbd_stride #(
    .DIM_W(DIM_W), .FINE_SH(FINE_SH), .COARSE_SH(COARSE_SH)
  ) i_stride (
    .width(sh_width), .fmt(sh_fmt), .fine(sh_fine), .stride(sh_stride)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fb_format_o <= 2'd0;
      act_fine    <= 1'b0;
      fb_width_o  <= '0;
      fb_height_o <= '0;
      fb_base_o   <= '0;
      fb_stride_o <= '0;
      vbl_pulse_o <= 1'b0;
    end else begin
      vbl_pulse_o <= commit;
      if (commit) begin
        fb_format_o <= sh_fmt;
        act_fine    <= sh_fine;
        fb_width_o  <= sh_width;
        fb_height_o <= sh_height;
        fb_base_o   <= sh_base;
        fb_stride_o <= sh_stride;
      end
    end
  end

  fbd_rowaddr #(
    .ADDR_W(ADDR_W), .DIM_W(DIM_W), .STR_W(STR_W)
  ) i_row (
    .clk(clk), .rst(rst), .base(fb_base_o), .stride(fb_stride_o),
    .height(fb_height_o), .row(row_i), .addr(row_addr_o)
  );

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!swap_pend_o && !vbl_pulse_o && fb_base_o == '0));
  // R5
  base_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !vbl_pulse_o |-> $stable(fb_base_o));
  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (rst)
    vbl_pulse_o |=> !vbl_pulse_o);
  // R3
  stride_align_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_stride_o[FINE_SH-1:0] == '0) &&
    (act_fine || fb_stride_o[COARSE_SH-1:0] == '0));
endmodule

// File: tb/test_fb_desc_ctrl.sv
module test_fb_desc_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_off = 4'h0;
  logic [31:0] wr_data = '0;
  logic        vblank_i = 1'b0;
  logic [11:0] row_i = '0;
  logic        fb_enable_o, swap_pend_o, vbl_pulse_o;
  logic [1:0]  fb_format_o;
  logic [11:0] fb_width_o, fb_height_o;
  logic [31:0] fb_base_o, row_addr_o;
  logic [14:0] fb_stride_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fb_desc_ctrl i_fb_desc_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_off(wr_off), .wr_data(wr_data),
    .vblank_i(vblank_i), .row_i(row_i), .fb_enable_o(fb_enable_o),
    .fb_format_o(fb_format_o), .fb_width_o(fb_width_o),
    .fb_height_o(fb_height_o), .fb_base_o(fb_base_o),
    .fb_stride_o(fb_stride_o), .row_addr_o(row_addr_o),
    .swap_pend_o(swap_pend_o), .vbl_pulse_o(vbl_pulse_o)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] off, input logic [31:0] d);
    wr_en = 1'b1; wr_off = off; wr_data = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0;
  endtask

  // raises vblank, leaves the caller at the first cycle showing committed values
  task automatic vbl_rise();
    vblank_i = 1'b1;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic vbl_fall();
    vblank_i = 1'b0;
    @(posedge clk); @(negedge clk);
  endtask

  function automatic int exp_stride(input int w, input int f, input int fine);
    int b = w * (f + 1);
    int g = fine ? 16 : 256;
    return ((b + g - 1) / g) * g;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk + 1);
    $finish;
  end

  initial begin
    int widths[10] = '{1, 15, 16, 17, 255, 256, 257, 800, 1024, 4095};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 base", fb_base_o, 0);
    check("R1 stride", fb_stride_o, 0);
    check("R1 flags", {fb_enable_o, swap_pend_o, vbl_pulse_o}, 0);

    // R8 enable immediate
    wr(4'h0, 32'h1);
    check("R8 enable", fb_enable_o, 1);
    check("R8 no commit", fb_width_o, 0);

    // R2 writes held in shadow
    wr(4'h4, {4'h0, 12'd480, 4'h0, 12'd640});
    wr(4'h8, 32'h0040_0000);
    repeat (3) @(negedge clk);
    check("R2 width held", fb_width_o, 0);
    check("R2 base held", fb_base_o, 0);
    check("R4 pending set", swap_pend_o, 1);

    // R6 R4 commit
    vbl_rise();
    check("R6 pulse", vbl_pulse_o, 1);
    check("R6 width", fb_width_o, 640);
    check("R6 height", fb_height_o, 480);
    check("R6 base", fb_base_o, 32'h0040_0000);
    check("R4 pending clear", swap_pend_o, 0);
    @(negedge clk);
    check("R6 pulse one cycle", vbl_pulse_o, 0);

    // R5 writes during held vblank do not commit
    wr(4'h8, 32'h0080_0000);
    repeat (4) @(negedge clk);
    check("R5 held high", fb_base_o, 32'h0040_0000);
    check("R5 pending", swap_pend_o, 1);
    vbl_fall();
    check("R5 fall no commit", fb_base_o, 32'h0040_0000);
    vbl_rise();
    check("R5 rise commits", fb_base_o, 32'h0080_0000);
    vbl_fall();

    // R3 stride sweep
    for (int f = 0; f < 4; f++)
      for (int g = 0; g < 2; g++)
        for (int i = 0; i < 10; i++) begin
          wr(4'h0, {28'd0, g[0], f[1:0], 1'b1});
          wr(4'h4, {4'h0, 12'd4, 4'h0, widths[i][11:0]});
          vbl_rise();
          check($sformatf("R3 stride w=%0d f=%0d fine=%0d", widths[i], f, g),
                fb_stride_o, exp_stride(widths[i], f, g));
          check("R3 format", fb_format_o, f);
          vbl_fall();
        end
    // R3 named example: 800 px, 3 bytes
    wr(4'h0, 32'h5);
    wr(4'h4, {4'h0, 12'd5, 4'h0, 12'd800});
    wr(4'h8, 32'h1000_0000);
    vbl_rise();
    check("R3 800x24 coarse", fb_stride_o, 2560);
    vbl_fall();

    // R7 row address with clamp
    for (int r = 0; r < 8; r++) begin
      row_i = r[11:0];
      #1;
      check($sformatf("R7 row %0d", r), row_addr_o,
            32'h1000_0000 + ((r < 5) ? r : 4) * 2560);
      @(negedge clk);
    end
    wr(4'h0, 32'hD);
    vbl_rise();
    check("R3 800x24 fine", fb_stride_o, 2400);
    row_i = 12'd2; #1;
    check("R7 fine row 2", row_addr_o, 32'h1000_0000 + 2 * 2400);
    vbl_fall();
    wr(4'h4, {4'h0, 12'd0, 4'h0, 12'd800});
    vbl_rise();
    row_i = 12'd9; #1;
    check("R7 zero height", row_addr_o, 32'h1000_0000);
    vbl_fall();

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule